// File: doc/BRIEF.md
# Time-Shared Rectangular-Tile Wide Multiplier

This block forms the complete unsigned product of two 72-bit operands. It has one rectangular 24-by-18 unsigned multiplier and uses it once per cycle. The first operand is cut into three 24-bit slices and the second into four 18-bit slices. That gives twelve slice products, each 42 bits wide. Each product is weighted by the sum of its two slice offsets.

The three products that pair slice k of the first operand with slice k of the second sit at weights 0, 42 and 84. Their bit ranges never overlap, so they are written side by side into the sum vector, with no addition. The nine remaining products are folded in one per cycle through a carry-save stage. Carry propagation is held back until the last product arrives. In that cycle one 3:2 compression and a single carry-propagate add produce the result.

The host raises `start` while the block is idle. The operands are sampled on that edge, `busy` stays high during the computation, and a one-cycle `done` pulse marks the new `product`.

Top module: `asym_tile_mult`

## Requirements
- R1: While reset is held and after it is released, `busy` and `done` are 0 and `product` is all zeros.
- R2: A rising clock edge with `start`=1 and `busy`=0 samples `op_x` and `op_y`, and `busy` is 1 after that edge. Later changes on the operand inputs do not affect the running computation.
- R3: `start` has no effect while `busy` is 1: the running computation is neither restarted nor resampled.
- R4: `done` is a one-cycle pulse. It is high after the 12th rising edge that follows the sampling edge. `busy` goes low on that same edge.
- R5: When `done` is high, `product` equals the full 144-bit unsigned product of the sampled operands.
- R6: `product` changes only on the edge that raises `done`, and keeps its value through idle periods and through the next computation.
- R7: The latency of 12 cycles does not depend on the operand values.
- R8: The carry-save accumulation never produces a carry beyond bit 143, including when both operands are all ones.
- R9: The three equal-index slice products (weights 0, 42, 84) are placed by concatenation before any carry-save step, and the carry vector stays zero while they are placed. An operand pair whose only nonzero slices are x1 and y1 (bits 47:24 and 35:18) yields exactly their product shifted left by 42.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a computation; accepted only while idle |
| op_x | input | 72 | First operand, cut into 24-bit slices |
| op_y | input | 72 | Second operand, cut into 18-bit slices |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle pulse: result valid |
| product | output | 144 | Unsigned product, held until the next completion |

## Verification
The embedded properties check every cycle that `done` lasts one cycle, that it arrives exactly twelve cycles after acceptance, and that `busy` falls with it. They also check that the captured operands and `product` stay stable outside their update edges, that the carry vector is zero during the concatenation phase, and that the carry-save and final adds never carry out of the top bit. The numerical correctness of the result can only be shown by the bench scenarios, which compare against a behavioral 144-bit product. These use zeros, all ones, single-bit operands, a diagonal-only pattern and random values. Only the scenarios show that operand changes and repeated `start` pulses during a computation are ignored.

// File: rtl/atm_pkg.sv
package atm_pkg;

  localparam int unsigned XSLICE_W = 24;
  localparam int unsigned YSLICE_W = 18;
  localparam int unsigned X_SLICES = 3;
  localparam int unsigned Y_SLICES = 4;

  // number of equal-index slice pairs (placed by concatenation)
  function automatic int diag_count(input int nx, input int ny);
    return (nx < ny) ? nx : ny;
  endfunction

  // schedule: equal-index pairs first, then the rest in y-major order
  function automatic int sched_x(input int k, input int nx, input int ny);
    int nd, seen, r;
    nd = diag_count(nx, ny);
    r = 0;
    if (k < nd) r = k;
    else begin
      seen = nd;
      for (int j = 0; j < ny; j++)
        for (int i = 0; i < nx; i++)
          if (i != j) begin
            if (seen == k) r = i;
            seen++;
          end
    end
    return r;
  endfunction

  function automatic int sched_y(input int k, input int nx, input int ny);
    int nd, seen, r;
    nd = diag_count(nx, ny);
    r = 0;
    if (k < nd) r = k;
    else begin
      seen = nd;
      for (int j = 0; j < ny; j++)
        for (int i = 0; i < nx; i++)
          if (i != j) begin
            if (seen == k) r = j;
            seen++;
          end
    end
    return r;
  endfunction

  function automatic int slice_weight(input int i, input int j, input int xw, input int yw);
    return i * xw + j * yw;
  endfunction

endpackage

// File: rtl/atm_seq.sv
module atm_seq #(
  parameter int unsigned N_STEPS = 12,
  parameter int unsigned SW      = $clog2(N_STEPS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic          launch,
  output logic          last_step,
  output logic [SW-1:0] step
);

  assign launch    = start & ~busy;
  assign last_step = busy && (step == SW'(N_STEPS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      step <= '0;
    end else begin
      done <= 1'b0;
      if (launch) begin
        busy <= 1'b1;
        step <= '0;
      end else if (busy) begin
        if (last_step) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          step <= step + 1'b1;
        end
      end
    end
  end

  // latency window counter for the checks below
  logic [SW:0] lat_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)      lat_cnt <= '0;
    else if (launch) lat_cnt <= '0;
    else if (busy)   lat_cnt <= lat_cnt + 1'b1;
  end

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_busy_falls_with_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  assert_not_busy_at_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_start_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_step) |=> (busy && step == $past(step) + 1'b1));
  assert_fixed_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_cnt == (SW+1)'(N_STEPS)));

endmodule

// File: rtl/atm_submul.sv
module atm_submul #(
  parameter int unsigned AW = 24,
  parameter int unsigned BW = 18
) (
  input  logic [AW-1:0]    a,
  input  logic [BW-1:0]    b,
  output logic [AW+BW-1:0] p
);
  assign p = {{BW{1'b0}}, a} * {{AW{1'b0}}, b};
endmodule

// File: rtl/atm_csa_acc.sv
module atm_csa_acc #(
  parameter int unsigned W     = 144,
  parameter int unsigned PW    = 42,
  parameter int unsigned NDIAG = 3,
  parameter int unsigned SLW   = (NDIAG > 1) ? $clog2(NDIAG) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clear,
  input  logic           diag_we,
  input  logic [SLW-1:0] diag_slot,
  input  logic           csa_en,
  input  logic           final_en,
  input  logic [PW-1:0]  pp_raw,
  input  logic [W-1:0]   addend,
  output logic [W-1:0]   result
);

  function automatic logic [W-1:0] fa_sum(input logic [W-1:0] a, b, c);
    return a ^ b ^ c;
  endfunction

  function automatic logic [W-1:0] fa_maj(input logic [W-1:0] a, b, c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  logic [W-1:0] sum_q, carry_q;
  logic [W-1:0] cs_sum, cs_maj, cs_carry, cpa_sum;
  logic         cpa_cout;

  always_comb begin
    cs_sum   = fa_sum(sum_q, carry_q, addend);
    cs_maj   = fa_maj(sum_q, carry_q, addend);
    cs_carry = {cs_maj[W-2:0], 1'b0};
    {cpa_cout, cpa_sum} = {1'b0, cs_sum} + {1'b0, cs_carry};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sum_q   <= '0;
      carry_q <= '0;
      result  <= '0;
    end else begin
      if (clear) begin
        sum_q   <= '0;
        carry_q <= '0;
      end else if (diag_we) begin
        sum_q[int'(diag_slot)*PW +: PW] <= pp_raw;
      end else if (csa_en) begin
        sum_q   <= cs_sum;
        carry_q <= cs_carry;
      end
      if (final_en) result <= cpa_sum;
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    csa_en |-> !cs_maj[W-1]);
  assert_no_cpa_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    final_en |-> !cpa_cout);
  assert_diag_carry_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    diag_we |-> (carry_q == '0));

endmodule

// File: rtl/asym_tile_mult.sv
module asym_tile_mult #(
  parameter int unsigned XCW = atm_pkg::XSLICE_W,
  parameter int unsigned YCW = atm_pkg::YSLICE_W,
  parameter int unsigned NXC = atm_pkg::X_SLICES,
  parameter int unsigned NYC = atm_pkg::Y_SLICES
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  input  logic [XCW*NXC-1:0]             op_x,
  input  logic [YCW*NYC-1:0]             op_y,
  output logic                           busy,
  output logic                           done,
  output logic [XCW*NXC+YCW*NYC-1:0]     product
);
  import atm_pkg::*;

  localparam int unsigned OPX_W = XCW * NXC;
  localparam int unsigned OPY_W = YCW * NYC;
  localparam int unsigned PW    = XCW + YCW;
  localparam int unsigned RW    = OPX_W + OPY_W;
  localparam int unsigned NPP   = NXC * NYC;
  localparam int unsigned NDIAG = diag_count(NXC, NYC);
  localparam int unsigned SW    = $clog2(NPP);
  localparam int unsigned SLW   = (NDIAG > 1) ? $clog2(NDIAG) : 1;

  logic          launch, last_step;
  logic [SW-1:0] step;

  atm_seq #(.N_STEPS(NPP), .SW(SW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .launch(launch), .last_step(last_step), .step(step)
  );

  logic [OPX_W-1:0] xr;
  logic [OPY_W-1:0] yr;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xr <= '0;
      yr <= '0;
    end else if (launch) begin
      xr <= op_x;
      yr <= op_y;
    end
  end

  int           cur_i, cur_j, shamt;
  logic [XCW-1:0] x_slice;
  logic [YCW-1:0] y_slice;
  logic [PW-1:0]  pp;
  logic [RW-1:0]  addend;
  logic           diag_we, csa_en;

  always_comb begin
    cur_i   = sched_x(int'(step), NXC, NYC);
    cur_j   = sched_y(int'(step), NXC, NYC);
    shamt   = slice_weight(cur_i, cur_j, XCW, YCW);
    x_slice = xr[cur_i*XCW +: XCW];
    y_slice = yr[cur_j*YCW +: YCW];
    addend  = RW'(pp) << shamt;
    diag_we = busy && (int'(step) < NDIAG);
    csa_en  = busy && !diag_we;
  end

  atm_submul #(.AW(XCW), .BW(YCW)) u_mul (.a(x_slice), .b(y_slice), .p(pp));

  atm_csa_acc #(.W(RW), .PW(PW), .NDIAG(NDIAG), .SLW(SLW)) u_acc (
    .clk(clk), .rst_n(rst_n), .clear(launch), .diag_we(diag_we),
    .diag_slot(SLW'(cur_i)), .csa_en(csa_en), .final_en(last_step),
    .pp_raw(pp), .addend(addend), .result(product)
  );

  assert_operands_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(xr) && $stable(yr)));
  assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(product));
  assert_diag_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
    diag_we |-> (cur_i == cur_j));
  assert_launch_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy);

endmodule

// File: tb/tb_asym_tile_mult.sv
module tb_asym_tile_mult;
  timeunit 1ns;
  timeprecision 1ps;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [71:0]  op_x = '0;
  logic [71:0]  op_y = '0;
  logic         busy, done;
  logic [143:0] product;

  int nchk = 0;
  int nfail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  asym_tile_mult dut (.clk(clk), .rst_n(rst_n), .start(start), .op_x(op_x),
    .op_y(op_y), .busy(busy), .done(done), .product(product));

  task automatic chk(input bit ok, input string tag, input logic [143:0] act, input logic [143:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [143:0] ref_mul(input logic [71:0] a, input logic [71:0] b);
    logic [143:0] acc = '0;
    for (int k = 0; k < 72; k++)
      if (b[k]) acc = acc + ({72'b0, a} << k);
    return acc;
  endfunction

  // launch one product; optionally press start again while busy (R3)
  task automatic run_op(input logic [71:0] a, input logic [71:0] b, input string tag, input bit poke);
    int n;
    logic [143:0] exp;
    exp = ref_mul(a, b);
    @(negedge clk);
    op_x = a; op_y = b; start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    op_x = ~a; op_y = ~b ^ 72'h5;
    chk(busy === 1'b1, {"R2 busy after accept ", tag}, {143'b0, busy}, 144'd1);
    n = 0;
    while (!done && n < 40) begin
      if (poke && n >= 2 && n < 6) start = 1'b1; else start = 1'b0;
      @(posedge clk); @(negedge clk);
      n++;
    end
    start = 1'b0;
    chk(n == 12, {"R4 R7 latency ", tag}, 144'(n), 144'd12);
    chk(busy === 1'b0, {"R4 busy low at done ", tag}, {143'b0, busy}, 144'd0);
    chk(product === exp, {"R5 product ", tag}, product, exp);
    @(posedge clk); @(negedge clk);
    chk(done === 1'b0, {"R4 done pulse width ", tag}, {143'b0, done}, 144'd0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R1 flags in reset", {142'b0, busy, done}, 144'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(product === '0, "R1 product after reset", product, 144'd0);
    chk(busy === 1'b0, "R1 idle after reset", {143'b0, busy}, 144'd0);
  endtask

  task automatic t_corners();
    run_op('0, '0, "zero*zero", 1'b0);
    run_op({72{1'b1}}, {72{1'b1}}, "R8 all ones", 1'b0);
    run_op({72{1'b1}}, '0, "R7 ones*zero", 1'b0);
    run_op(72'd1 << 71, 72'd1 << 71, "msb*msb", 1'b0);
    run_op(72'd1, 72'd1 << 40, "one*bit40", 1'b0);
    run_op(72'd1 << 23, 72'd1 << 17, "slice edges", 1'b0);
  endtask

  task automatic t_diag_only();
    logic [71:0] a, b;
    a = 72'(24'hABCDEF) << 24;
    b = 72'(18'h2F0F1) << 18;
    run_op(a, b, "R9 diagonal only x1 y1", 1'b0);
    chk(product === (144'(48'(24'hABCDEF) * 48'(18'h2F0F1)) << 42),
        "R9 shifted by 42", product, 144'(48'(24'hABCDEF) * 48'(18'h2F0F1)) << 42);
  endtask

  task automatic t_busy_start();
    run_op(72'h123456789ABCDEF012, 72'hFEDCBA9876543210AB, "R3 start while busy", 1'b1);
    @(negedge clk);
    chk(busy === 1'b0, "R3 no relaunch", {143'b0, busy}, 144'd0);
  endtask

  task automatic t_hold();
    logic [143:0] held;
    held = product;
    repeat (5) begin
      @(negedge clk);
      chk(product === held, "R6 hold while idle", product, held);
    end
    @(negedge clk);
    op_x = 72'h3; op_y = 72'h5; start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    repeat (6) begin
      chk(product === held, "R6 hold while busy", product, held);
      @(negedge clk);
    end
    while (!done) @(negedge clk);
    chk(product === 144'd15, "R6 updates at done", product, 144'd15);
  endtask

  task automatic t_random();
    for (int r = 0; r < 20; r++) begin
      logic [71:0] a, b;
      a = {$urandom(), $urandom(), $urandom()};
      b = {$urandom(), $urandom(), $urandom()};
      run_op(a, b, "R5 random", 1'b0);
    end
  endtask

  initial begin
    t_reset();
    t_corners();
    t_diag_only();
    t_busy_start();
    t_hold();
    t_random();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

endmodule